// File: doc/BRIEF.md
# Reconfigurable Partial Cyclic Shifter

This block is a pipelined routing network for a multi-mode quasi-cyclic LDPC decoder. Each transfer carries a vector of 256 soft values, each 9 bits wide. The block rotates either the whole vector or only a leading window of `p` lanes by a run-time amount `c`. Window sizes from 64 to 256 in steps of 8 let one datapath serve every supported expansion factor.

Each vector brings its own window size and shift amount, so consecutive vectors may use different modes without any idle cycle. The controls are decoded two clocks after acceptance. The rotated vector leaves the block four clocks after acceptance. Both directions use a valid/ready handshake:
- A vector is taken on a rising edge where `in_valid` and `in_ready` are both high.
- A result is delivered on a rising edge where `out_valid` and `out_ready` are both high.
- While a result waits with `out_ready` low, the whole pipeline holds.

Top module: `pcs_rotator`

## Requirements
- R1: Lane `j` occupies bits `[9j+8:9j]`, with lanes numbered from 0. When `in_plen` is 256, output lane `j` equals input lane `(c-1+j) mod 256`, where `c` is `in_shift`.
- R2: When `in_plen` is a legal `p` below 256, output lane `j` equals input lane `(c-1+j) mod p` for every `j < p`.
- R3: For a legal vector, every output lane `j >= p` is zero.
- R4: A vector is legal when `p` is a multiple of 8 in 64..256 and `c` lies in 1..p. For any other vector, `out_err` is 1 and all of `out_data` is zero. For a legal vector, `out_err` is 0.
- R5: With `out_ready` held high, a vector accepted on one rising edge appears on `out_valid` after the fourth rising edge, counting the accepting edge as the first. A new vector is accepted every clock with no bubbles, whatever the mix of modes.
- R6: `in_ready` equals `out_ready OR NOT out_valid`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_err` hold their values.
- R7: Synchronous active-high `rst` empties the pipeline. After reset, `out_valid` is 0 and `in_ready` is 1, and no vector accepted before the reset is delivered.
- R8: Results leave in acceptance order. Under any pattern of stalls, no result is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block can take a vector this cycle |
| in_data | input | 2304 | 256 lanes of 9 bits |
| in_plen | input | 9 | Window size p for this vector |
| in_shift | input | 9 | Shift amount c for this vector, 1-based |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 2304 | Rotated lanes |
| out_err | output | 1 | Illegal window size or shift amount in this vector |

## Verification
The bench targets the following corner cases:

- **Wrap points.** `c` equal to 1 must leave the window unchanged, and `c` equal to `p` must bring the last window lane to lane 0. An off-by-one in the window-crossing threshold would shift the lanes on one side of the wrap.
- **Window edge.** The smallest window (64) and near-full windows (248) test the boundary. A mux that picks the wrong rotated copy near that edge would pull in lanes from outside the window. A design that forgot to clear the upper lanes would leak input data there.
- **Illegal controls.** Sizes off the step of 8, out-of-range sizes, and shift amounts of 0 or `p+1` must raise `out_err` with blank data.
- **Stalls.** Random stalls interleaved with mode changes from one vector to the next, plus a reset in mid-stream, expose three faults: a control stage that slips against its data, a stall that drops or repeats a vector, and a reset that lets stale results out.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int LANES    = 256;
  localparam int LANE_W   = 9;
  localparam int P_MIN    = 64;
  localparam int P_STEP   = 8;
  localparam int IDXW     = $clog2(LANES);
  localparam int PW       = IDXW + 1;
  localparam int STEPW    = $clog2(P_STEP);
  localparam int LO_LAYERS = IDXW / 2;
  localparam int HI_LAYERS = IDXW - LO_LAYERS;
  localparam int VEC_W    = LANES * LANE_W;

  typedef logic [LANES-1:0][LANE_W-1:0] lane_vec_t;

  typedef struct packed {
    logic [IDXW-1:0] rot_a;   // rotation for lanes that do not cross the window end
    logic [IDXW-1:0] rot_b;   // rotation for lanes that wrap inside the window
    logic [PW-1:0]   thresh;  // first lane taking the wrapped copy
    logic [PW-1:0]   plen;    // lanes at or above this index are blanked
    logic            err;
  } ctl_t;
endpackage

// File: rtl/pcs_ctrl_decode.sv
module pcs_ctrl_decode
  import pcs_pkg::*;
(
  input  logic [PW-1:0] plen_i,
  input  logic [PW-1:0] shift_i,
  output ctl_t          ctl_o
);
  logic          size_ok;
  logic          shift_ok;
  logic [PW-1:0] r;
  logic [PW-1:0] rb_full;

  always_comb begin
    size_ok  = (plen_i >= PW'(P_MIN)) && (plen_i <= PW'(LANES)) &&
               (plen_i[STEPW-1:0] == '0);
    shift_ok = (shift_i >= PW'(1)) && (shift_i <= plen_i);
    r        = shift_i - PW'(1);
    rb_full  = r + PW'(LANES) - plen_i;
    if (size_ok && shift_ok) begin
      ctl_o.rot_a  = r[IDXW-1:0];
      ctl_o.rot_b  = rb_full[IDXW-1:0];
      ctl_o.thresh = plen_i - r;
      ctl_o.plen   = plen_i;
      ctl_o.err    = 1'b0;
    end else begin
      ctl_o.rot_a  = '0;
      ctl_o.rot_b  = '0;
      ctl_o.thresh = '0;
      ctl_o.plen   = '0;
      ctl_o.err    = 1'b1;
    end
  end
endmodule

// File: rtl/pcs_barrel_part.sv
module pcs_barrel_part
  import pcs_pkg::*;
#(
  parameter int FIRST = 0,
  parameter int COUNT = 4
) (
  input  lane_vec_t       d_i,
  input  logic [IDXW-1:0] amt_i,
  output lane_vec_t       d_o
);
  lane_vec_t lvl [COUNT+1];

  assign lvl[0] = d_i;

  for (genvar g = 0; g < COUNT; g++) begin : g_layer
    localparam int STRIDE = 1 << (FIRST + g);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign lvl[g+1][j] = amt_i[FIRST+g] ? lvl[g][(j + STRIDE) % LANES] : lvl[g][j];
    end
  end

  assign d_o = lvl[COUNT];
endmodule

// File: rtl/pcs_lane_select.sv
module pcs_lane_select
  import pcs_pkg::*;
(
  input  lane_vec_t     a_i,
  input  lane_vec_t     b_i,
  input  logic [PW-1:0] plen_i,
  input  logic [PW-1:0] thresh_i,
  output lane_vec_t     d_o
);
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      if (PW'(j) >= plen_i)        d_o[j] = '0;
      else if (PW'(j) >= thresh_i) d_o[j] = b_i[j];
      else                         d_o[j] = a_i[j];
    end
  end
endmodule

// File: rtl/pcs_rotator.sv
module pcs_rotator
  import pcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_data,
  input  logic [PW-1:0]    in_plen,
  input  logic [PW-1:0]    in_shift,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data,
  output logic             out_err
);
  logic adv;
  assign adv      = out_ready || !out_valid;
  assign in_ready = adv;

  // stage 1: capture
  logic          v1;
  lane_vec_t     d1;
  logic [PW-1:0] p1, c1;
  // stage 2: decoded controls
  logic          v2;
  lane_vec_t     d2;
  ctl_t          ctl_dec, c2;
  // stage 3: low rotation layers
  logic          v3;
  lane_vec_t     part3 [2];
  lane_vec_t     part_lo [2];
  ctl_t          c3;
  // stage 4: high layers and window select
  lane_vec_t     part_hi [2];
  lane_vec_t     sel;
  lane_vec_t     d4;
  logic          v4, e4;

  logic [IDXW-1:0] amt2 [2];
  logic [IDXW-1:0] amt3 [2];

  pcs_ctrl_decode u_dec (
    .plen_i (p1),
    .shift_i(c1),
    .ctl_o  (ctl_dec)
  );

  assign amt2[0] = c2.rot_a;
  assign amt2[1] = c2.rot_b;
  assign amt3[0] = c3.rot_a;
  assign amt3[1] = c3.rot_b;

  for (genvar k = 0; k < 2; k++) begin : g_path
    pcs_barrel_part #(.FIRST(0), .COUNT(LO_LAYERS)) u_lo (
      .d_i  (d2),
      .amt_i(amt2[k]),
      .d_o  (part_lo[k])
    );
    pcs_barrel_part #(.FIRST(LO_LAYERS), .COUNT(HI_LAYERS)) u_hi (
      .d_i  (part3[k]),
      .amt_i(amt3[k]),
      .d_o  (part_hi[k])
    );
  end

  pcs_lane_select u_sel (
    .a_i     (part_hi[0]),
    .b_i     (part_hi[1]),
    .plen_i  (c3.plen),
    .thresh_i(c3.thresh),
    .d_o     (sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      v4 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
      v4 <= v3;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      d1       <= in_data;
      p1       <= in_plen;
      c1       <= in_shift;
      d2       <= d1;
      c2       <= ctl_dec;
      part3[0] <= part_lo[0];
      part3[1] <= part_lo[1];
      c3       <= c2;
      d4       <= sel;
      e4       <= c3.err;
    end
  end

  assign out_valid = v4;
  assign out_data  = d4;
  assign out_err   = e4;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_err)); // R6
  AST_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> out_valid); // R6
  AST_ERR_BLANK: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_err |-> out_data == '0); // R4
  AST_ROT_RANGE: assert property (@(posedge clk) disable iff (rst)
    v2 && !c2.err |-> {1'b0, c2.rot_a} < c2.plen); // R2
  AST_THRESH_RANGE: assert property (@(posedge clk) disable iff (rst)
    v2 && !c2.err |-> c2.thresh != '0 && c2.thresh <= c2.plen); // R2
endmodule

// File: tb/pcs_rotator_test.sv
module pcs_rotator_test;
  import pcs_pkg::*;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic             in_ready;
  logic [VEC_W-1:0] in_data;
  logic [PW-1:0]    in_plen;
  logic [PW-1:0]    in_shift;
  logic             out_valid;
  logic             out_ready;
  logic [VEC_W-1:0] out_data;
  logic             out_err;

  always #5 clk = ~clk;

  pcs_rotator uut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_plen(in_plen), .in_shift(in_shift),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_err(out_err)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [VEC_W-1:0] q_data [$];
  logic             q_err  [$];
  int               q_p    [$];

  logic             stalled = 1'b0;
  logic [VEC_W-1:0] held_d;
  logic             held_e;

  function automatic logic [VEC_W-1:0] rnd_vec();
    logic [VEC_W-1:0] v;
    for (int j = 0; j < LANES; j++) v[j*LANE_W +: LANE_W] = LANE_W'($urandom);
    return v;
  endfunction

  function automatic logic is_legal(int p, int c);
    return (p >= 64) && (p <= 256) && (p % 8 == 0) && (c >= 1) && (c <= p);
  endfunction

  function automatic logic [VEC_W-1:0] model(logic [VEC_W-1:0] d, int p, int c);
    logic [VEC_W-1:0] e = '0;
    if (is_legal(p, c))
      for (int j = 0; j < p; j++)
        e[j*LANE_W +: LANE_W] = d[((c - 1 + j) % p)*LANE_W +: LANE_W];
    return e;
  endfunction

  task automatic check_out(logic [VEC_W-1:0] exp_d, logic exp_e, int p);
    n_chk++;
    if (out_err !== exp_e) begin
      n_bad++;
      $display("FAIL R4: out_err act=%0b exp=%0b (p=%0d)", out_err, exp_e, p);
    end
    for (int j = 0; j < LANES; j++) begin
      if (out_data[j*LANE_W +: LANE_W] !== exp_d[j*LANE_W +: LANE_W]) begin
        n_bad++;
        $display("FAIL %s: lane %0d act=%0h exp=%0h (p=%0d)",
                 exp_e ? "R4" : (j >= p ? "R3" : (p == 256 ? "R1" : "R2")),
                 j, out_data[j*LANE_W +: LANE_W], exp_d[j*LANE_W +: LANE_W], p);
        break;
      end
    end
  endtask

  // one clock: check held state, drive, then account for both handshakes
  task automatic step(logic v, logic [VEC_W-1:0] d, int p, int c, logic rdy);
    @(negedge clk);
    if (stalled) begin
      n_chk++;
      if (!out_valid || out_data !== held_d || out_err !== held_e) begin
        n_bad++;
        $display("FAIL R6: stalled result changed act_v=%0b exp_v=1", out_valid);
      end
    end
    in_valid  = v;
    in_data   = d;
    in_plen   = PW'(p);
    in_shift  = PW'(c);
    out_ready = rdy;
    #1;
    n_chk++;
    if (in_ready !== (rdy || !out_valid)) begin
      n_bad++;
      $display("FAIL R6: in_ready act=%0b exp=%0b", in_ready, rdy || !out_valid);
    end
    if (v && in_ready) begin
      q_data.push_back(model(d, p, c));
      q_err.push_back(!is_legal(p, c));
      q_p.push_back(p);
    end
    if (out_valid && rdy) begin
      if (q_data.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R8: unexpected result act=1 exp=0 pending");
      end else begin
        check_out(q_data.pop_front(), q_err.pop_front(), q_p.pop_front());
      end
    end
    stalled = out_valid && !rdy;
    held_d  = out_data;
    held_e  = out_err;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 256, 1, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    rst = 1'b1; in_valid = 1'b0; in_data = '0; in_plen = '0; in_shift = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    n_chk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R7: after reset valid=%0b ready=%0b exp 0/1", out_valid, in_ready);
    end

    // R5: latency of a single vector
    step(1'b1, rnd_vec(), 256, 5, 1'b1);
    lat = 0;
    do begin
      lat++;
      step(1'b0, '0, 256, 1, 1'b1);
    end while (!out_valid && lat < 10);
    n_chk++;
    if (lat != 4) begin
      n_bad++;
      $display("FAIL R5: latency act=%0d exp=4", lat);
    end
    idle(2);

    // R1 R2 R3 corner windows, back to back with no bubbles (R5)
    step(1'b1, rnd_vec(), 256, 1,   1'b1);
    step(1'b1, rnd_vec(), 256, 256, 1'b1);
    step(1'b1, rnd_vec(), 64,  1,   1'b1);
    step(1'b1, rnd_vec(), 64,  64,  1'b1);
    step(1'b1, rnd_vec(), 248, 248, 1'b1);
    step(1'b1, rnd_vec(), 248, 2,   1'b1);
    step(1'b1, rnd_vec(), 128, 77,  1'b1);
    step(1'b1, rnd_vec(), 200, 100, 1'b1);
    // R4 illegal controls
    step(1'b1, rnd_vec(), 63,  1,   1'b1);
    step(1'b1, rnd_vec(), 65,  3,   1'b1);
    step(1'b1, rnd_vec(), 264, 1,   1'b1);
    step(1'b1, rnd_vec(), 128, 0,   1'b1);
    step(1'b1, rnd_vec(), 128, 129, 1'b1);
    step(1'b1, rnd_vec(), 0,   0,   1'b1);
    idle(6);

    // R7: reset mid-stream discards pending vectors
    step(1'b1, rnd_vec(), 96, 7, 1'b1);
    step(1'b1, rnd_vec(), 96, 8, 1'b1);
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    q_data.delete(); q_err.delete(); q_p.delete(); stalled = 1'b0;
    for (int i = 0; i < 6; i++) begin
      n_chk++;
      if (out_valid !== 1'b0) begin
        n_bad++;
        $display("FAIL R7: stale result act=%0b exp=0", out_valid);
      end
      step(1'b0, '0, 256, 1, 1'b1);
    end

    // R6 R8: random traffic with stalls and per-vector modes
    for (int i = 0; i < 1500; i++) begin
      int p, c;
      p = 64 + 8 * int'($urandom % 25);
      c = 1 + int'($urandom % p);
      if ($urandom % 16 == 0) c = p + 1;
      step(($urandom % 4) != 0, rnd_vec(), p, c, ($urandom % 3) != 0);
    end
    idle(10);
    n_chk++;
    if (q_data.size() != 0) begin
      n_bad++;
      $display("FAIL R8: pending act=%0d exp=0", q_data.size());
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule